// File: doc/BRIEF.md
# Hot-Swap Insertion and Fault Isolation Sequencer

This block sequences one power module of a redundant, parallel-connected supply. When it is brought into the system it first runs the module at a low self-test level. During this test the input switch is still open, so the input bus reaches the module only through its pre-charge resistor. It then closes the input switch and waits until the module's own output voltage tracks the shared bus. Only then does it close the output switch and raise the current-limit setpoint in steps from a small starting value to full rating. Removal runs the same ramp the other way before the module is switched off.

While the output switch is closed, the block watches for a shorted module. The sign is the regulator sitting in current limit while the output is close to zero volts. When that happens the output switch opens and a dwell timer starts. If the module's own output has not recovered above the short threshold when the dwell ends, the module is shut down and a fault is latched. Otherwise the output switch closes again and operation continues. The regulation loop and all analog sensing are outside this block. The block only reads digitised voltage and current values and a current-limit-active flag.

Top module: `hsw_ctrl`

## Requirements
- R1: Reset, which takes effect asynchronously, gives state code 0 (off). In this state both switches are open, run and self-test are low, the fault flag is low and the current-limit setpoint equals ILIM_MIN.
- R2: With enable high in state 0, the block enters state 1 (self-test). In state 1 the input switch is open and run and self-test are high. After TEST_CYC cycles in state 1 the block moves to state 2 (matching), where the input switch is closed, run is high and self-test is low.
- R3: If the measured current exceeds TEST_IMAX in state 1, the block goes to state 7 (fault). In state 7 the fault flag is high and both switches, run and self-test are low.
- R4: In state 2 the output switch closes only once |vout - vbus| <= MATCH_WIN has held for MATCH_CNT consecutive cycles. Any sample outside the window restarts the count. On success the block enters state 3 (ramp up).
- R5: In state 3 the setpoint starts at ILIM_MIN and rises by ILIM_STEP every RAMP_DIV cycles, clamped at ILIM_MAX. On reaching ILIM_MAX the block enters state 4 (on).
- R6: Enable low in state 3 or 4 leads to state 6 (ramp down). There the output switch stays closed and the setpoint falls by ILIM_STEP every RAMP_DIV cycles, clamped at ILIM_MIN. On reaching ILIM_MIN the block returns to state 0. Enable high again in state 6 resumes state 3 from the present setpoint. Enable low in state 1 or 2 returns directly to state 0.
- R7: With the output switch closed, if current limit is active and vout < SHORT_MV, the output switch opens on the next cycle and the block enters state 5 (isolating). In state 5 the input switch and run stay high and the setpoint is held.
- R8: If vout <= SHORT_MV when ISO_CYC cycles in state 5 have elapsed, the block enters state 7 and latches the fault.
- R9: If vout > SHORT_MV when the state 5 dwell ends, the output switch closes again. The block goes to state 3 (state 6 if enable is low) and continues from the held setpoint.
- R10: The fault flag stays high while enable stays high. Enable low moves state 7 to state 0 and clears the flag. A new start then needs enable high.
- R11: Current limit with vout >= SHORT_MV causes no isolation.
- R12: The output switch is never closed while the input switch is open. The setpoint always lies within ILIM_MIN..ILIM_MAX.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Module enable command |
| vout_i | input | V_W | Module-side output voltage, mV |
| vbus_i | input | V_W | Shared output bus voltage, mV |
| iout_i | input | I_W | Module output current, setpoint units |
| ilim_act_i | input | 1 | Regulator is in current limit |
| in_sw_o | output | 1 | Close input isolation switch |
| out_sw_o | output | 1 | Close output isolation switch |
| run_o | output | 1 | Regulator run enable |
| selftest_o | output | 1 | Regulator targets the self-test voltage level |
| ilim_o | output | I_W | Current-limit setpoint |
| fault_o | output | 1 | Latched short-circuit or self-test fault |
| state_o | output | 3 | Present state code |

## Verification
Some properties are checked on every cycle. These are the switch ordering, the setpoint range and its per-cycle step bound, the next-cycle opening of the output switch on a short, the holding of the setpoint during isolation, and the persistence of a fault while enable stays high. The following depend on sequences that only the bench scenarios can set up, with timing computed from the parameters:
- the exact self-test and isolation dwell lengths;
- the restart of the match count after an out-of-window sample;
- the setpoint value at given points in a ramp;
- the boundary outcomes at exactly the short threshold;
- the resume of the ramp from a partly ramped-down setpoint.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_TEST  = 3'd1,
    ST_MATCH = 3'd2,
    ST_RISE  = 3'd3,
    ST_ON    = 3'd4,
    ST_ISO   = 3'd5,
    ST_FALL  = 3'd6,
    ST_FAULT = 3'd7
  } hsw_state_e;

  typedef struct packed {
    logic in_sw;
    logic out_sw;
    logic run;
    logic test;
    logic fault;
  } hsw_drv_t;

  function automatic hsw_drv_t drive_of(hsw_state_e s);
    hsw_drv_t d;
    d = '0;
    case (s)
      ST_TEST:  begin d.run = 1'b1; d.test = 1'b1; end
      ST_MATCH,
      ST_ISO:   begin d.in_sw = 1'b1; d.run = 1'b1; end
      ST_RISE,
      ST_ON,
      ST_FALL:  begin d.in_sw = 1'b1; d.out_sw = 1'b1; d.run = 1'b1; end
      ST_FAULT: d.fault = 1'b1;
      default:  d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/hsw_dwell.sv
module hsw_dwell #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = active && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!active) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (!expired) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hsw_match.sv
module hsw_match #(
  parameter int V_W   = 16,
  parameter int WIN   = 50,
  parameter int COUNT = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic [V_W-1:0] vout,
  input  logic [V_W-1:0] vbus,
  output logic           matched
);
  localparam int CW = $clog2(COUNT + 1);
  localparam logic [CW-1:0]  LAST  = CW'(COUNT - 1);
  localparam logic [V_W-1:0] WIN_V = V_W'(WIN);

  logic [V_W-1:0] diff;
  logic           in_win;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           cnt_en;

  assign diff    = (vout >= vbus) ? (vout - vbus) : (vbus - vout);
  assign in_win  = (diff <= WIN_V);
  assign matched = active && in_win && (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!active || !in_win) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (!matched) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hsw_ramp.sv
module hsw_ramp #(
  parameter int I_W  = 16,
  parameter int MIN  = 10,
  parameter int MAX  = 400,
  parameter int STEP = 10,
  parameter int DIV  = 1000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rise,
  input  logic           fall,
  input  logic           park,
  output logic [I_W-1:0] level,
  output logic           at_max,
  output logic           at_min
);
  localparam int DW = $clog2(DIV + 1);
  localparam logic [DW-1:0]  DLAST = DW'(DIV - 1);
  localparam logic [I_W-1:0] LO    = I_W'(MIN);
  localparam logic [I_W-1:0] HI    = I_W'(MAX);
  localparam logic [I_W-1:0] STP   = I_W'(STEP);

  logic [DW-1:0]  div_q, div_d;
  logic           div_en, moving, tick;
  logic [I_W-1:0] lvl_q, lvl_d;
  logic           lvl_en;

  assign moving = rise || fall;
  assign tick   = moving && (div_q == DLAST);
  assign level  = lvl_q;
  assign at_max = (lvl_q == HI);
  assign at_min = (lvl_q == LO);

  always_comb begin
    div_en = 1'b1;
    if (!moving || tick) begin
      div_d  = '0;
      div_en = (div_q != '0);
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_comb begin
    lvl_d  = lvl_q;
    lvl_en = 1'b0;
    if (park) begin
      lvl_d  = LO;
      lvl_en = (lvl_q != LO);
    end else if (tick && rise) begin
      lvl_d  = ((HI - lvl_q) <= STP) ? HI : (lvl_q + STP);
      lvl_en = 1'b1;
    end else if (tick && fall) begin
      lvl_d  = ((lvl_q - LO) <= STP) ? LO : (lvl_q - STP);
      lvl_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= LO;
    else if (lvl_en) lvl_q <= lvl_d;
  end
endmodule

// File: rtl/hsw_ctrl.sv
module hsw_ctrl #(
  parameter int V_W       = 16,
  parameter int I_W       = 16,
  parameter int TEST_CYC  = 50000,
  parameter int TEST_IMAX = 20,
  parameter int MATCH_WIN = 50,
  parameter int MATCH_CNT = 16,
  parameter int ILIM_MIN  = 10,
  parameter int ILIM_MAX  = 400,
  parameter int ILIM_STEP = 10,
  parameter int RAMP_DIV  = 1000,
  parameter int SHORT_MV  = 500,
  parameter int ISO_CYC   = 2000000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic [V_W-1:0] vout_i,
  input  logic [V_W-1:0] vbus_i,
  input  logic [I_W-1:0] iout_i,
  input  logic           ilim_act_i,
  output logic           in_sw_o,
  output logic           out_sw_o,
  output logic           run_o,
  output logic           selftest_o,
  output logic [I_W-1:0] ilim_o,
  output logic           fault_o,
  output logic [2:0]     state_o
);
  import hsw_pkg::*;

  localparam logic [V_W-1:0] SHORT_V = V_W'(SHORT_MV);
  localparam logic [I_W-1:0] TEST_I  = I_W'(TEST_IMAX);

  logic [1:0] rs_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_int = rs_q[1];

  hsw_state_e state_q, state_d;
  hsw_drv_t   drv;
  logic       test_done, iso_done, matched, at_max, at_min;
  logic       short_seen, vout_ok, test_over;
  logic       rise, fall, park;

  assign short_seen = ilim_act_i && (vout_i < SHORT_V);
  assign vout_ok    = (vout_i > SHORT_V);
  assign test_over  = (iout_i > TEST_I);

  assign rise = (state_q == ST_RISE);
  assign fall = (state_q == ST_FALL);
  assign park = (state_q == ST_OFF) || (state_q == ST_FAULT) ||
                (state_q == ST_TEST) || (state_q == ST_MATCH);

  hsw_dwell #(.LIMIT(TEST_CYC)) u_test_dwell (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .active  (state_q == ST_TEST),
    .expired (test_done)
  );

  hsw_dwell #(.LIMIT(ISO_CYC)) u_iso_dwell (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .active  (state_q == ST_ISO),
    .expired (iso_done)
  );

  hsw_match #(.V_W(V_W), .WIN(MATCH_WIN), .COUNT(MATCH_CNT)) u_match (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .active  (state_q == ST_MATCH),
    .vout    (vout_i),
    .vbus    (vbus_i),
    .matched (matched)
  );

  hsw_ramp #(
    .I_W(I_W), .MIN(ILIM_MIN), .MAX(ILIM_MAX), .STEP(ILIM_STEP), .DIV(RAMP_DIV)
  ) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .rise   (rise),
    .fall   (fall),
    .park   (park),
    .level  (ilim_o),
    .at_max (at_max),
    .at_min (at_min)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_OFF:   if (en_i) state_d = ST_TEST;
      ST_TEST: begin
        if (!en_i)          state_d = ST_OFF;
        else if (test_over) state_d = ST_FAULT;
        else if (test_done) state_d = ST_MATCH;
      end
      ST_MATCH: begin
        if (!en_i)        state_d = ST_OFF;
        else if (matched) state_d = ST_RISE;
      end
      ST_RISE: begin
        if (short_seen)  state_d = ST_ISO;
        else if (!en_i)  state_d = ST_FALL;
        else if (at_max) state_d = ST_ON;
      end
      ST_ON: begin
        if (short_seen)  state_d = ST_ISO;
        else if (!en_i)  state_d = ST_FALL;
      end
      ST_FALL: begin
        if (short_seen)  state_d = ST_ISO;
        else if (en_i)   state_d = ST_RISE;
        else if (at_min) state_d = ST_OFF;
      end
      ST_ISO: begin
        if (iso_done) begin
          if (!vout_ok)  state_d = ST_FAULT;
          else if (en_i) state_d = ST_RISE;
          else           state_d = ST_FALL;
        end
      end
      ST_FAULT: if (!en_i) state_d = ST_OFF;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)           state_q <= ST_OFF;
    else if (state_d != state_q) state_q <= state_d;
  end

  assign drv        = drive_of(state_q);
  assign in_sw_o    = drv.in_sw;
  assign out_sw_o   = drv.out_sw;
  assign run_o      = drv.run;
  assign selftest_o = drv.test;
  assign fault_o    = drv.fault;
  assign state_o    = state_q;
endmodule

// File: rtl/hsw_ctrl_chk.sv
module hsw_ctrl_chk #(
  parameter int V_W       = 16,
  parameter int I_W       = 16,
  parameter int ILIM_MIN  = 10,
  parameter int ILIM_MAX  = 400,
  parameter int ILIM_STEP = 10,
  parameter int SHORT_MV  = 500
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en_i,
  input logic [V_W-1:0] vout_i,
  input logic           ilim_act_i,
  input logic           in_sw_o,
  input logic           out_sw_o,
  input logic           run_o,
  input logic           selftest_o,
  input logic [I_W-1:0] ilim_o,
  input logic           fault_o,
  input logic [2:0]     state_o
);
  localparam logic [I_W-1:0] LO  = I_W'(ILIM_MIN);
  localparam logic [I_W-1:0] HI  = I_W'(ILIM_MAX);
  localparam logic [I_W-1:0] STP = I_W'(ILIM_STEP);
  localparam logic [V_W-1:0] SV  = V_W'(SHORT_MV);

  a_r12_out_needs_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_sw_o |-> in_sw_o);

  a_r12_ilim_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_o >= LO) && (ilim_o <= HI));

  a_r5_ilim_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sw_o && $past(out_sw_o)) |->
      (((ilim_o >= $past(ilim_o)) ? (ilim_o - $past(ilim_o))
                                  : ($past(ilim_o) - ilim_o)) <= STP));

  a_r7_short_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sw_o && ilim_act_i && (vout_i < SV)) |=> !out_sw_o);

  a_r7_iso_holds_ilim: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd5) && ($past(state_o) == 3'd5)) |-> (ilim_o == $past(ilim_o)));

  a_r2_test_switches_open: assert property (@(posedge clk) disable iff (!rst_n)
    selftest_o |-> (!in_sw_o && !out_sw_o && run_o));

  a_r10_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && en_i) |=> fault_o);

  a_r3_fault_safe: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!in_sw_o && !out_sw_o && !run_o && !selftest_o));
endmodule

bind hsw_ctrl hsw_ctrl_chk #(
  .V_W(V_W), .I_W(I_W), .ILIM_MIN(ILIM_MIN), .ILIM_MAX(ILIM_MAX),
  .ILIM_STEP(ILIM_STEP), .SHORT_MV(SHORT_MV)
) u_hsw_chk (
  .clk        (clk),
  .rst_n      (rst_n_int),
  .en_i       (en_i),
  .vout_i     (vout_i),
  .ilim_act_i (ilim_act_i),
  .in_sw_o    (in_sw_o),
  .out_sw_o   (out_sw_o),
  .run_o      (run_o),
  .selftest_o (selftest_o),
  .ilim_o     (ilim_o),
  .fault_o    (fault_o),
  .state_o    (state_o)
);

// File: tb/test_hsw_ctrl.sv
module test_hsw_ctrl;
  localparam int V_W = 16;
  localparam int I_W = 16;

  typedef struct packed {
    logic        en;
    logic        act;
    logic [15:0] vout;
    logic [15:0] vbus;
    logic [15:0] iout;
    logic [7:0]  cyc;
    logic [2:0]  st;
    logic [4:0]  outs;
    logic [15:0] ilim;
    logic [3:0]  req;
  } vec_t;

  // outs = {in_sw, out_sw, run, selftest, fault}
  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    {1'b0,1'b0,16'd0,    16'd0,    16'd0,  8'd5,  3'd0,5'b00000,16'd10, 4'd1},  // R1 idle
    {1'b1,1'b0,16'd300,  16'd12000,16'd5,  8'd3,  3'd1,5'b00110,16'd10, 4'd2},  // R2 self-test
    {1'b1,1'b0,16'd300,  16'd12000,16'd5,  8'd10, 3'd2,5'b10100,16'd10, 4'd2},  // R2 to matching
    {1'b1,1'b0,16'd12000,16'd12040,16'd5,  8'd3,  3'd2,5'b10100,16'd10, 4'd4},  // R4 count 3 of 4
    {1'b1,1'b0,16'd12000,16'd12051,16'd5,  8'd1,  3'd2,5'b10100,16'd10, 4'd4},  // R4 out of window
    {1'b1,1'b0,16'd12000,16'd12040,16'd5,  8'd3,  3'd2,5'b10100,16'd10, 4'd4},  // R4 restarted
    {1'b1,1'b0,16'd12000,16'd12040,16'd5,  8'd6,  3'd3,5'b11100,16'd60, 4'd5},  // R5 first step
    {1'b1,1'b0,16'd12000,16'd12040,16'd5,  8'd40, 3'd4,5'b11100,16'd400,4'd5},  // R5 clamp at max
    {1'b1,1'b1,16'd12000,16'd12040,16'd5,  8'd5,  3'd4,5'b11100,16'd400,4'd11}, // R11 limit, normal v
    {1'b1,1'b1,16'd200,  16'd12040,16'd5,  8'd3,  3'd5,5'b10100,16'd400,4'd7},  // R7 isolate
    {1'b1,1'b0,16'd800,  16'd12040,16'd5,  8'd25, 3'd4,5'b11100,16'd400,4'd9},  // R9 recovered
    {1'b1,1'b1,16'd100,  16'd12040,16'd5,  8'd25, 3'd7,5'b00001,16'd10, 4'd8},  // R8 shorted
    {1'b1,1'b0,16'd12000,16'd12040,16'd5,  8'd5,  3'd7,5'b00001,16'd10, 4'd10}, // R10 latched
    {1'b0,1'b0,16'd12000,16'd12040,16'd5,  8'd3,  3'd0,5'b00000,16'd10, 4'd10}, // R10 cleared
    {1'b1,1'b0,16'd300,  16'd12040,16'd5,  8'd12, 3'd2,5'b10100,16'd10, 4'd2},  // R2 restart
    {1'b1,1'b0,16'd12000,16'd12040,16'd5,  8'd40, 3'd4,5'b11100,16'd400,4'd5},  // R5 full ramp
    {1'b0,1'b0,16'd12000,16'd12040,16'd5,  8'd10, 3'd6,5'b11100,16'd300,4'd6},  // R6 ramp down
    {1'b0,1'b0,16'd12000,16'd12040,16'd5,  8'd40, 3'd0,5'b00000,16'd10, 4'd6},  // R6 off at min
    {1'b1,1'b0,16'd300,  16'd12040,16'd200,8'd5,  3'd7,5'b00001,16'd10, 4'd3},  // R3 abort
    {1'b0,1'b0,16'd300,  16'd12040,16'd5,  8'd3,  3'd0,5'b00000,16'd10, 4'd10}, // R10 clear
    {1'b1,1'b0,16'd300,  16'd12040,16'd5,  8'd12, 3'd2,5'b10100,16'd10, 4'd2}   // R2 again
  };

  logic           clk, rst_n, en, act;
  logic [V_W-1:0] vout, vbus;
  logic [I_W-1:0] iout;
  logic           in_sw_o, out_sw_o, run_o, selftest_o, fault_o;
  logic [I_W-1:0] ilim_o;
  logic [2:0]     state_o;
  int             n_chk, n_fail;

  hsw_ctrl #(
    .V_W(V_W), .I_W(I_W), .TEST_CYC(8), .TEST_IMAX(100), .MATCH_WIN(50),
    .MATCH_CNT(4), .ILIM_MIN(10), .ILIM_MAX(400), .ILIM_STEP(50),
    .RAMP_DIV(4), .SHORT_MV(500), .ISO_CYC(20)
  ) i_hsw_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .vout_i(vout), .vbus_i(vbus),
    .iout_i(iout), .ilim_act_i(act), .in_sw_o(in_sw_o), .out_sw_o(out_sw_o),
    .run_o(run_o), .selftest_o(selftest_o), .ilim_o(ilim_o),
    .fault_o(fault_o), .state_o(state_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic drive(input logic e, input logic a, input int vo, input int vb, input int io);
    en = e; act = a; vout = V_W'(vo); vbus = V_W'(vb); iout = I_W'(io);
  endtask

  task automatic run_cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [2:0] st, input logic [4:0] outs,
                       input logic [15:0] il);
    logic [4:0] got;
    got = {in_sw_o, out_sw_o, run_o, selftest_o, fault_o};
    n_chk++;
    if (state_o !== st || got !== outs || ilim_o !== il) begin
      n_fail++;
      $display("FAIL %s: state=%0d outs=%b ilim=%0d expected state=%0d outs=%b ilim=%0d",
               tag, state_o, got, ilim_o, st, outs, il);
    end
    // R12 invariant seen at the ports
    n_chk++;
    if ((out_sw_o && !in_sw_o) || ilim_o < 10 || ilim_o > 400) begin
      n_fail++;
      $display("FAIL R12: out_sw=%b in_sw=%b ilim=%0d expected switch order and 10..400",
               out_sw_o, in_sw_o, ilim_o);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 0, 0, 0);
    run_cycles(3);
    rst_n = 1'b1;
    run_cycles(3);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = TBL[i];
      drive(v.en, v.act, int'(v.vout), int'(v.vbus), int'(v.iout));
      run_cycles(int'(v.cyc));
      check($sformatf("R%0d step %0d", v.req, i), v.st, v.outs, v.ilim);
    end

    // bring to on, then drop enable briefly and resume (R6)
    drive(1'b1, 1'b0, 12000, 12000, 5);
    run_cycles(60);
    check("R5 on before resume", 3'd4, 5'b11100, 16'd400);
    drive(1'b0, 1'b0, 12000, 12000, 5);
    run_cycles(6);
    check("R6 partly down", 3'd6, 5'b11100, 16'd350);
    drive(1'b1, 1'b0, 12000, 12000, 5);
    run_cycles(2);
    check("R6 resume ramp up", 3'd3, 5'b11100, 16'd350);
    run_cycles(10);
    check("R6 back on", 3'd4, 5'b11100, 16'd400);

    // current limit at exactly the threshold: no isolation (R11)
    drive(1'b1, 1'b1, 500, 12000, 5);
    run_cycles(5);
    check("R11 at threshold", 3'd4, 5'b11100, 16'd400);

    // isolation, output reaches exactly the threshold: fault (R8)
    drive(1'b1, 1'b1, 100, 12000, 5);
    run_cycles(2);
    check("R7 isolating", 3'd5, 5'b10100, 16'd400);
    drive(1'b1, 1'b0, 500, 12000, 5);
    run_cycles(25);
    check("R8 not above threshold", 3'd7, 5'b00001, 16'd10);

    // asynchronous reset while on (R1)
    drive(1'b0, 1'b0, 12000, 12000, 5);
    run_cycles(3);
    drive(1'b1, 1'b0, 12000, 12000, 5);
    run_cycles(60);
    check("R5 on before reset", 3'd4, 5'b11100, 16'd400);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", 3'd0, 5'b00000, 16'd10);
    drive(1'b0, 1'b0, 0, 0, 0);
    run_cycles(2);
    rst_n = 1'b1;
    run_cycles(4);
    check("R1 after release", 3'd0, 5'b00000, 16'd10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule